// File: doc/BRIEF.md
# PLL Divider Chain: Reference Prescaler, Feedback Divider and Output Post-Divider

This block holds the digital dividers that sit around a PLL. A fixed prescaler divides the crystal clock down to the phase-detector reference. A feedback divider divides the VCO clock by a programmable count M, followed by a halving stage, so a locked loop runs the VCO at 2·M times the reference. A post-divider derives the output clock from the VCO clock, with a ratio of 1, 2, 4 or 8.

The feedback and output dividers run in the VCO clock domain, and the prescaler runs in the reference domain. New M, ratio-code and enable values are taken only at a divider period boundary, so a reprogramming never truncates a pulse that is already on a pin. An M outside the lockable window is still divided exactly as given, and a flag reports it. The phase detector, charge pump and oscillator lie outside this block.

Top module: `synth_divider_chain`

## Requirements
- R1: `ref_div_o` is a square wave with a period of 16 reference clocks, high for 8 and low for 8, starting low after reset.
- R2: `fb_clk_o` has a period of 2·M VCO clocks. It holds each level for exactly M VCO clocks, where M is the active feedback count.
- R3: A new `m_val_i` is adopted only when the M counter wraps. A level already in progress on `fb_clk_o` finishes with the old M, and the following level uses the new M.
- R4: `m_range_err_o` is high exactly when the active M is below 125 or above 350. Such an M is still divided as given.
- R5: `n_code_i` 00 divides by 2, 01 by 4 and 10 by 8, and each ratio gives a 50% duty cycle on `out_clk_o`.
- R6: `n_code_i` 11 gives divide-by-1: `out_clk_o` is a gated copy of the VCO clock, high while the VCO clock is high.
- R7: While the active enable (taken from `oe_i`) is low, `out_clk_o` stays low. A change of `oe_i` takes effect at an output period boundary.
- R8: A new `n_code_i` is adopted only at the end of a high level of the divided output (or at any VCO edge in divide-by-1), so the high level in progress keeps the old length.
- R9: While `rst_ni` is low, all three clock outputs are low, the active M is all ones (flag high) and the active ratio code is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Crystal or reference input clock |
| vco_clk_i | input | 1 | VCO clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| m_val_i | input | MW (9) | Requested feedback count M |
| n_code_i | input | 2 | Output ratio code: 00 ÷2, 01 ÷4, 10 ÷8, 11 ÷1 |
| oe_i | input | 1 | Output clock enable |
| ref_div_o | output | 1 | Reference to the phase detector, input ÷16 |
| fb_clk_o | output | 1 | Feedback clock, VCO ÷(2·M) |
| out_clk_o | output | 1 | Divided output clock |
| m_range_err_o | output | 1 | Active M lies outside 125..350 |

## Verification
A corrupted M counter or active M shows on `fb_clk_o` as a level of the wrong length within one feedback period, up to 2·M VCO clocks. A counter or toggle fault in the post-divider changes the edge count and the high-time count of `out_clk_o` in a 1000-cycle window, within one output period. Loading M or the ratio code at the wrong moment is caught by measuring the single level in which the change lands: with the value taken at the boundary, that level keeps its old length. An early load makes that level longer or shorter.

// File: rtl/synth_div_pkg.sv
`timescale 1ns/1ps
package synth_div_pkg;

    // Output ratio code; the order is not monotonic, 11 selects divide-by-1
    typedef enum logic [1:0] {
        NDIV_2 = 2'b00,
        NDIV_4 = 2'b01,
        NDIV_8 = 2'b10,
        NDIV_1 = 2'b11
    } ndiv_e;

    localparam int unsigned HCNT_W = 2;

    // Last count value of one half period for the divided ratios
    function automatic logic [HCNT_W-1:0] half_last(input ndiv_e code);
        case (code)
            NDIV_4:  return 2'd1;
            NDIV_8:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ref_prescaler.sv
`timescale 1ns/1ps
module ref_prescaler #(
    parameter int unsigned REF_DIV = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ref_o
);
    localparam int unsigned CW   = $clog2(REF_DIV);
    localparam int unsigned HALF = REF_DIV / 2;
    localparam int unsigned RW   = CW + 1;
    localparam logic [RW-1:0] HALF_R = RW'(HALF);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // MSB of a power-of-two counter gives a symmetric square wave
    assign ref_o = st_q.cnt[CW-1];

    // Checker: length of the level held on ref_o
    logic          prev_q;
    logic [RW-1:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= ref_o;
            run_q  <= (ref_o != prev_q) ? RW'(1) : run_q + 1'b1;
        end
    end

    AST_REF_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_o != prev_q) |-> (run_q == HALF_R)); // R1

endmodule

// File: rtl/fb_divider.sv
`timescale 1ns/1ps
module fb_divider #(
    parameter int unsigned MW    = 9,
    parameter int unsigned M_MIN = 125,
    parameter int unsigned M_MAX = 350
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [MW-1:0] m_val_i,
    output logic          fb_o,
    output logic          m_err_o
);
    localparam logic [MW-1:0] M_RST   = '1;
    localparam logic [MW-1:0] M_LO    = MW'(M_MIN);
    localparam logic [MW-1:0] M_HI    = MW'(M_MAX);
    localparam logic          ERR_RST = (M_RST < M_LO) || (M_RST > M_HI);

    typedef struct packed {
        logic [MW-1:0] cnt;
        logic [MW-1:0] m_act;
        logic          fb;
        logic          err;
    } st_t;

    st_t  st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == st_q.m_act - 1'b1);
        if (wrap) begin
            // the M counter need not be symmetric; the halving toggle is
            st_d.cnt   = '0;
            st_d.fb    = ~st_q.fb;
            st_d.m_act = m_val_i;
            st_d.err   = (m_val_i < M_LO) || (m_val_i > M_HI);
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.m_act <= M_RST;
            st_q.fb    <= 1'b0;
            st_q.err   <= ERR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_o    = st_q.fb;
    assign m_err_o = st_q.err;

    AST_FB_EDGE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.fb != $past(st_q.fb)) |-> (st_q.cnt == '0)); // R2
    AST_FB_M_LOAD_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.m_act != $past(st_q.m_act)) |-> (st_q.cnt == '0)); // R3
    AST_FB_FLAG_WITH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.err != $past(st_q.err)) |-> (st_q.cnt == '0)); // R4

endmodule

// File: rtl/out_divider.sv
`timescale 1ns/1ps
module out_divider
    import synth_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] n_code_i,
    input  logic       oe_i,
    output logic       clk_o
);
    typedef struct packed {
        logic [HCNT_W-1:0] cnt;
        logic              tog;
        ndiv_e             n_act;
        logic              en;
    } st_t;

    st_t  st_d, st_q;
    logic div1, term, bound;
    logic gate_q;

    always_comb begin
        st_d  = st_q;
        div1  = (st_q.n_act == NDIV_1);
        term  = (st_q.cnt == half_last(st_q.n_act));
        bound = div1 | (term & st_q.tog);
        if (div1) begin
            st_d.cnt = '0;
            st_d.tog = 1'b0;
        end else if (term) begin
            st_d.cnt = '0;
            st_d.tog = ~st_q.tog;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (bound) begin
            st_d.n_act = ndiv_e'(n_code_i);
            st_d.en    = oe_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.tog   <= 1'b0;
            st_q.n_act <= NDIV_1;
            st_q.en    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // divide-by-1 gate moves only while the VCO clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= st_q.en & (st_q.n_act == NDIV_1);
    end

    assign clk_o = (clk_i & gate_q) | (st_q.tog & st_q.en & (st_q.n_act != NDIV_1));

    AST_OUT_LOAD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.n_act != $past(st_q.n_act)) || (st_q.en != $past(st_q.en)))
        |-> (st_q.cnt == '0 && !st_q.tog)); // R8
    AST_OUT_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.en && !gate_q) |-> !clk_o); // R7
    AST_OUT_GATE_ONLY_DIV1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q.n_act) != NDIV_1 && st_q.n_act != NDIV_1) |-> !gate_q); // R6

endmodule

// File: rtl/synth_divider_chain.sv
`timescale 1ns/1ps
module synth_divider_chain #(
    parameter int unsigned REF_DIV = 16,
    parameter int unsigned MW      = 9,
    parameter int unsigned M_MIN   = 125,
    parameter int unsigned M_MAX   = 350
) (
    input  logic          ref_clk_i,
    input  logic          vco_clk_i,
    input  logic          rst_ni,
    input  logic [MW-1:0] m_val_i,
    input  logic [1:0]    n_code_i,
    input  logic          oe_i,
    output logic          ref_div_o,
    output logic          fb_clk_o,
    output logic          out_clk_o,
    output logic          m_range_err_o
);

    ref_prescaler #(.REF_DIV(REF_DIV)) u_ref (
        .clk_i  (ref_clk_i),
        .rst_ni (rst_ni),
        .ref_o  (ref_div_o)
    );

    fb_divider #(.MW(MW), .M_MIN(M_MIN), .M_MAX(M_MAX)) u_fb (
        .clk_i   (vco_clk_i),
        .rst_ni  (rst_ni),
        .m_val_i (m_val_i),
        .fb_o    (fb_clk_o),
        .m_err_o (m_range_err_o)
    );

    out_divider u_out (
        .clk_i    (vco_clk_i),
        .rst_ni   (rst_ni),
        .n_code_i (n_code_i),
        .oe_i     (oe_i),
        .clk_o    (out_clk_o)
    );

endmodule

// File: tb/synth_divider_chain_tb_top.sv
`timescale 1ns/1ps
module synth_divider_chain_tb_top;
    localparam int MW = 9;
    localparam int K_WIN_OUT = 0, K_WIN_FB = 1, K_WIN_REF = 2,
                   K_PULSE_FB = 3, K_PULSE_OUT = 4, K_FLAG = 5;

    logic          ref_clk = 1'b0;
    logic          vco_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic [MW-1:0] m_val   = 9'd125;
    logic [1:0]    n_code  = 2'b00;
    logic          oe      = 1'b1;
    logic          ref_div, fb_clk, out_clk, m_err;

    synth_divider_chain dut_i (
        .ref_clk_i     (ref_clk),
        .vco_clk_i     (vco_clk),
        .rst_ni        (rst_n),
        .m_val_i       (m_val),
        .n_code_i      (n_code),
        .oe_i          (oe),
        .ref_div_o     (ref_div),
        .fb_clk_o      (fb_clk),
        .out_clk_o     (out_clk),
        .m_range_err_o (m_err)
    );

    always #10 ref_clk = ~ref_clk;   // 50 MHz
    always #1  vco_clk = ~vco_clk;

    int checks = 0;
    int errors = 0;

    // scoreboard queues, one entry per expected item
    int    q_kind[$];
    int    q_win[$];
    int    q_a[$];
    int    q_b[$];
    string q_req[$];
    bit    mon_busy = 1'b0;

    // samplers: twice per VCO cycle, once per reference cycle
    logic s_out = 1'b0, s_fb = 1'b0, s_ref = 1'b0;
    event ev_vs, ev_rs;
    initial forever begin
        @(vco_clk);
        #0.5;
        s_out = out_clk;
        s_fb  = fb_clk;
        -> ev_vs;
    end
    initial forever begin
        @(negedge ref_clk);
        s_ref = ref_div;
        -> ev_rs;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic enqueue(input int kind, input int win, input int a, input int b, input string req);
        q_kind.push_back(kind);
        q_win.push_back(win);
        q_a.push_back(a);
        q_b.push_back(b);
        q_req.push_back(req);
    endtask

    task automatic drain();
        wait (q_kind.size() == 0 && !mon_busy);
    endtask

    task automatic expect_item(input int kind, input int win, input int a, input int b, input string req);
        enqueue(kind, win, a, b, req);
        drain();
    endtask

    // monitor: pops each expected item and measures the design
    initial forever begin
        int kind, win, ea, eb, rises, highs, lows;
        string req;
        logic prev, v;
        wait (q_kind.size() > 0);
        kind = q_kind.pop_front();
        win  = q_win.pop_front();
        ea   = q_a.pop_front();
        eb   = q_b.pop_front();
        req  = q_req.pop_front();
        mon_busy = 1'b1;
        rises = 0;
        highs = 0;
        lows  = 0;
        case (kind)
            K_WIN_OUT, K_WIN_FB: begin
                prev = (kind == K_WIN_FB) ? s_fb : s_out;
                for (int i = 0; i < 2 * win; i++) begin
                    @(ev_vs);
                    v = (kind == K_WIN_FB) ? s_fb : s_out;
                    if (!prev && v) rises++;
                    if (v) highs++;
                    prev = v;
                end
                check(req, "rising edges", rises, ea);
                check(req, "high samples", highs, eb);
            end
            K_WIN_REF: begin
                prev = s_ref;
                for (int i = 0; i < win; i++) begin
                    @(ev_rs);
                    if (!prev && s_ref) rises++;
                    if (s_ref) highs++;
                    prev = s_ref;
                end
                check(req, "ref rising edges", rises, ea);
                check(req, "ref high samples", highs, eb);
            end
            K_PULSE_FB, K_PULSE_OUT: begin
                prev = (kind == K_PULSE_FB) ? s_fb : s_out;
                forever begin
                    @(ev_vs);
                    v = (kind == K_PULSE_FB) ? s_fb : s_out;
                    if (!prev && v) break;
                    prev = v;
                end
                highs = 1;
                forever begin
                    @(ev_vs);
                    v = (kind == K_PULSE_FB) ? s_fb : s_out;
                    if (!v) break;
                    highs++;
                end
                lows = 1;
                forever begin
                    @(ev_vs);
                    v = (kind == K_PULSE_FB) ? s_fb : s_out;
                    if (v) break;
                    lows++;
                end
                check(req, "high level samples", highs, ea);
                check(req, "next low level samples", lows, eb);
            end
            default: begin
                check(req, "range flag", int'(m_err), ea);
            end
        endcase
        mon_busy = 1'b0;
    end

    task automatic vco_wait(input int n);
        repeat (n) @(negedge vco_clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: state while reset is held
        repeat (3) @(negedge ref_clk);
        check("R9", "ref_div_o in reset", int'(ref_div), 0);
        check("R9", "fb_clk_o in reset", int'(fb_clk), 0);
        check("R9", "out_clk_o in reset", int'(out_clk), 0);
        check("R9", "flag in reset", int'(m_err), 1);
        rst_n = 1'b1;

        // R1: 160 reference cycles give 10 periods, 80 high
        expect_item(K_WIN_REF, 160, 10, 80, "R1");

        // R2, R4: M = 125, period 250 VCO cycles
        vco_wait(1200);
        expect_item(K_WIN_FB, 1000, 4, 1000, "R2");
        expect_item(K_FLAG, 0, 0, 0, "R4");

        // R2: M = 350, period 700
        m_val = 9'd350;
        vco_wait(1800);
        expect_item(K_WIN_FB, 1400, 2, 1400, "R2");
        expect_item(K_FLAG, 0, 0, 0, "R4");

        // R4: out-of-range values still divided
        m_val = 9'd100;
        vco_wait(1800);
        expect_item(K_WIN_FB, 1000, 5, 1000, "R4");
        expect_item(K_FLAG, 0, 1, 0, "R4");
        m_val = 9'd400;
        vco_wait(1800);
        expect_item(K_WIN_FB, 1600, 2, 1600, "R4");
        expect_item(K_FLAG, 0, 1, 0, "R4");

        // R3: change M inside a high level; that level keeps M = 125
        m_val = 9'd125;
        vco_wait(1800);
        @(negedge fb_clk);
        enqueue(K_PULSE_FB, 0, 250, 600, "R3");
        @(posedge fb_clk);
        vco_wait(10);
        m_val = 9'd300;
        drain();

        // R5: divided ratios, 1000-cycle windows
        n_code = 2'b00;
        vco_wait(40);
        expect_item(K_WIN_OUT, 1000, 500, 1000, "R5");
        n_code = 2'b01;
        vco_wait(40);
        expect_item(K_WIN_OUT, 1000, 250, 1000, "R5");
        n_code = 2'b10;
        vco_wait(40);
        expect_item(K_WIN_OUT, 1000, 125, 1000, "R5");

        // R6: code 11 follows the VCO clock
        n_code = 2'b11;
        vco_wait(40);
        expect_item(K_WIN_OUT, 1000, 1000, 1000, "R6");

        // R7: disabled output stays low, then resumes
        oe = 1'b0;
        n_code = 2'b00;
        vco_wait(40);
        expect_item(K_WIN_OUT, 1000, 0, 0, "R7");
        oe = 1'b1;
        vco_wait(40);
        expect_item(K_WIN_OUT, 1000, 500, 1000, "R7");

        // R8: ÷8 -> ÷2 inside a high level: 4 cycles high, then 1 low
        n_code = 2'b10;
        vco_wait(40);
        @(negedge out_clk);
        enqueue(K_PULSE_OUT, 0, 8, 2, "R8");
        @(posedge out_clk);
        @(negedge vco_clk);
        n_code = 2'b00;
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule